// File: doc/BRIEF.md
# Per-Channel Window Alarm Unit

This block keeps a 10-bit upper and a 10-bit lower limit for each of 16 analog channels and flags every conversion result that leaves its channel's window. Limits are loaded by a burst of command words, one per frame. The first frame of a burst names a group of four channels. Each later frame writes one limit in that group, until a frame carries the exit bit. The serial shifter outside this block hands over one committed 16-bit word at the end of each frame. It also passes the start of each frame and every serial-clock falling edge as single-cycle pulses, plus the result of the frame's conversion together with the channel that produced it.

The two alarm flags are active high. Both change only at fixed falling-edge counts inside the frame, so the pins they drive are stable while the rest of the word is shifted out. A 3-bit routing field chooses which of two general-purpose pins carry alarms, and in what combination.

Top module: `win_alarm_unit`

## Requirements
- R1: After reset every upper limit is 0x3FF, every lower limit is 0x000, both alarm flags are 0 and no burst is open.
- R2: Outside a burst, a committed word whose bits 15..14 are 11 opens a burst for group bits 13..12 (channels 4·group to 4·group+3). prog_active is 1 and prog_group shows the group from the next clock on. Any other word opens nothing.
- R3: Inside a burst, each committed word writes bits 9..0 into the limit of channel {group, bits 15..14}. Bit 13 selects the upper limit when 1 and the lower limit when 0.
- R4: A burst word with bit 12 = 1 is still written, and the burst then closes. A burst word with bit 12 = 0 keeps the burst open, so the next word is taken as limit data whatever its bits 15..12 are.
- R5: In full resolution (narrow_res = 0), result bits 11..2 are compared with the limits. The upper flag is set only when they are strictly greater than the upper limit, and the lower flag only when they are strictly less than the lower limit.
- R6: With narrow_res = 1, result bits 11..4 are compared with limit bits 9..2 under the same strict rules.
- R7: The flags take their compare value on the clock after the 12th serial falling edge of the frame whose result was captured, using the limits of the channel given with that result.
- R8: Flags that were set stay set until the clock after the 10th serial falling edge of the next frame, when both return to 0.
- R9: Routing field route: any value with bit 0 = 1 drives upper-or-lower on pin 0. 010 drives the upper flag on pin 0. 100 drives the lower flag on pin 1. 110 drives lower on pin 1 and upper on pin 0. 000 claims no pin. alarm_sel bit n is 1 when pin n is claimed, and an unclaimed alarm_pin bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse at the start of a frame |
| sclk_fall | input | 1 | Pulse for each serial-clock falling edge |
| cmd_valid | input | 1 | Pulse: cmd_word is a committed frame word |
| cmd_word | input | 16 | Committed command word |
| res_valid | input | 1 | Pulse: capture res_chan and res_data |
| res_chan | input | 4 | Channel that produced the result |
| res_data | input | 12 | Conversion result |
| narrow_res | input | 1 | 1 selects 8-bit compare |
| route | input | 3 | Alarm routing field |
| alarm_hi | output | 1 | Upper-limit alarm flag |
| alarm_lo | output | 1 | Lower-limit alarm flag |
| alarm_sel | output | 2 | Pins claimed by the alarm function |
| alarm_pin | output | 2 | Values driven on claimed pins |
| prog_active | output | 1 | Limit burst open |
| prog_group | output | 2 | Group of the open burst |

## Verification
A wrong limit address or a burst that stays open too long shows up on the first later frame whose result sits just beyond the affected limit. There the flags rise at the 12th edge when they should stay low, or stay low when they should rise. One strictly-greater and one equal value per window edge expose an off-by-one compare in the very frame it happens. A mis-counted edge moves the rise or fall of a flag by a single serial edge. The bench looks at the flags one edge before and one edge after each boundary, in the converting frame and the next one.

// File: rtl/win_alarm_unit.sv
module win_alarm_unit #(
  parameter int NCH      = 16,
  parameter int TW       = 10,
  parameter int RW       = 12,
  parameter int SET_EDGE = 12,
  parameter int CLR_EDGE = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        sclk_fall,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic        res_valid,
  input  logic [3:0]  res_chan,
  input  logic [11:0] res_data,
  input  logic        narrow_res,
  input  logic [2:0]  route,
  output logic        alarm_hi,
  output logic        alarm_lo,
  output logic [1:0]  alarm_sel,
  output logic [1:0]  alarm_pin,
  output logic        prog_active,
  output logic [1:0]  prog_group
);
  localparam int CW   = $clog2(NCH);
  localparam int NREG = 2 * NCH;
  localparam int NW   = TW - 2;

  logic [TW-1:0] lim [NREG];
  logic [4:0]    ecnt;
  logic [CW-1:0] cap_chan;
  logic [RW-1:0] cap_data;

  logic [CW:0]   wr_idx;
  logic [TW-1:0] hi_lim, lo_lim;
  logic [TW-1:0] top;
  logic          over, under;

  assign wr_idx = {prog_group, cmd_word[15:14], cmd_word[13]};
  assign hi_lim = lim[{cap_chan, 1'b1}];
  assign lo_lim = lim[{cap_chan, 1'b0}];
  assign top    = cap_data[RW-1 -: TW];
  assign over   = narrow_res ? (top[TW-1 -: NW] > hi_lim[TW-1 -: NW]) : (top > hi_lim);
  assign under  = narrow_res ? (top[TW-1 -: NW] < lo_lim[TW-1 -: NW]) : (top < lo_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_active <= 1'b0;
      prog_group  <= 2'd0;
    end else if (cmd_valid) begin
      if (!prog_active) begin
        if (cmd_word[15:14] == 2'b11) begin
          prog_active <= 1'b1;
          prog_group  <= cmd_word[13:12];
        end
      end else if (cmd_word[12]) begin
        prog_active <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lim[g] <= (g % 2 == 1) ? {TW{1'b1}} : {TW{1'b0}};
      else if (cmd_valid && prog_active && wr_idx == (CW+1)'(g))
        lim[g] <= cmd_word[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_chan <= '0;
      cap_data <= '0;
    end else if (res_valid) begin
      cap_chan <= res_chan[CW-1:0];
      cap_data <= res_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ecnt <= '0;
    else if (frame_start)
      ecnt <= '0;
    else if (sclk_fall && ecnt != 5'h1f)
      ecnt <= ecnt + 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_hi <= 1'b0;
      alarm_lo <= 1'b0;
    end else if (sclk_fall && !frame_start) begin
      if (ecnt == 5'(SET_EDGE - 1)) begin
        alarm_hi <= over;
        alarm_lo <= under;
      end else if (ecnt == 5'(CLR_EDGE - 1)) begin
        alarm_hi <= 1'b0;
        alarm_lo <= 1'b0;
      end
    end
  end

  logic both_pin0, hi_pin0, lo_pin1;
  assign both_pin0 = route[0];
  assign hi_pin0   = !route[0] && route[1];
  assign lo_pin1   = !route[0] && route[2];

  assign alarm_sel = {lo_pin1, both_pin0 | hi_pin0};
  assign alarm_pin = {lo_pin1 & alarm_lo,
                      (both_pin0 & (alarm_hi | alarm_lo)) | (hi_pin0 & alarm_hi)};
endmodule

module win_alarm_chk #(
  parameter int SET_EDGE = 12,
  parameter int CLR_EDGE = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        sclk_fall,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [2:0]  route,
  input logic        alarm_hi,
  input logic        alarm_lo,
  input logic [1:0]  alarm_sel,
  input logic        prog_active
);
  logic [4:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (frame_start) seen <= '0;
    else if (sclk_fall && seen != 5'h1f) seen <= seen + 5'd1;
  end

  // R2
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_active) |-> $past(cmd_valid) && $past(cmd_word[15:14]) == 2'b11);

  // R4
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_active) |-> $past(cmd_valid) && $past(cmd_word[12]));

  // R7
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_hi) |-> seen == 5'(SET_EDGE));

  // R7
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_lo) |-> seen == 5'(SET_EDGE));

  // R8
  hi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_hi) |-> seen == 5'(CLR_EDGE) || seen == 5'(SET_EDGE));

  // R8
  lo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_lo) |-> seen == 5'(CLR_EDGE) || seen == 5'(SET_EDGE));

  // R9
  idle_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route == 3'b000 |-> alarm_sel == 2'b00);
endmodule

bind win_alarm_unit win_alarm_chk #(.SET_EDGE(SET_EDGE), .CLR_EDGE(CLR_EDGE)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sclk_fall(sclk_fall),
  .cmd_valid(cmd_valid), .cmd_word(cmd_word), .route(route),
  .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .alarm_sel(alarm_sel),
  .prog_active(prog_active)
);

// File: tb/test_win_alarm_unit.sv
module test_win_alarm_unit;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, sclk_fall = 0, cmd_valid = 0, res_valid = 0, narrow_res = 0;
  logic [15:0] cmd_word = 0;
  logic [3:0]  res_chan = 0;
  logic [11:0] res_data = 0;
  logic [2:0]  route = 3'b110;
  logic alarm_hi, alarm_lo, prog_active;
  logic [1:0] alarm_sel, alarm_pin, prog_group;
  int runs = 0, fails = 0;
  logic prev_hi = 0, prev_lo = 0;

  always #2.5 clk = ~clk;

  win_alarm_unit i_win_alarm_unit (.*);

  // {route, narrow, chan, result, exp_hi, exp_lo}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {3'b110, 1'b0, 4'd1,  12'h804, 1'b1, 1'b0},
    {3'b110, 1'b0, 4'd1,  12'h800, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'd1,  12'h400, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'd1,  12'h3FC, 1'b0, 1'b1},
    {3'b110, 1'b0, 4'd0,  12'hFFF, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'd0,  12'h000, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'd2,  12'hFC8, 1'b1, 1'b0},
    {3'b110, 1'b0, 4'd15, 12'h1FC, 1'b0, 1'b1},
    {3'b110, 1'b0, 4'd8,  12'h0C0, 1'b0, 1'b1},
    {3'b110, 1'b1, 4'd1,  12'h80F, 1'b0, 1'b0},
    {3'b110, 1'b1, 4'd1,  12'h810, 1'b1, 1'b0},
    {3'b110, 1'b1, 4'd1,  12'h3F0, 1'b0, 1'b1},
    {3'b001, 1'b0, 4'd1,  12'h804, 1'b1, 1'b0},
    {3'b100, 1'b0, 4'd1,  12'h804, 1'b1, 1'b0},
    {3'b010, 1'b0, 4'd1,  12'h3FC, 1'b0, 1'b1},
    {3'b000, 1'b0, 4'd2,  12'hFC8, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] route_exp(input logic [2:0] r, input logic h, input logic l);
    logic [1:0] s, p;
    if (r[0])             begin s = 2'b01; p = {1'b0, h | l}; end
    else if (r == 3'b010) begin s = 2'b01; p = {1'b0, h}; end
    else if (r == 3'b100) begin s = 2'b10; p = {l, 1'b0}; end
    else if (r == 3'b110) begin s = 2'b11; p = {l, h}; end
    else                  begin s = 2'b00; p = 2'b00; end
    return {s, p};
  endfunction

  task automatic pulse_edge();
    @(negedge clk) sclk_fall = 1;
    @(negedge clk) sclk_fall = 0;
  endtask

  task automatic frame(input logic [15:0] cmd, input logic [2:0] rt, input logic nr,
                       input logic [3:0] ch, input logic [11:0] rs,
                       input logic eh, input logic el);
    route = rt; narrow_res = nr;
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0; res_valid = 1; res_chan = ch; res_data = rs;
    @(negedge clk) res_valid = 0;
    for (int e = 1; e <= 16; e++) begin
      pulse_edge();
      if (e == 9) begin
        // R8: previous frame's flags held through the 9th edge
        chk(alarm_hi == prev_hi && alarm_lo == prev_lo, "R8 hold", {alarm_hi, alarm_lo}, {prev_hi, prev_lo});
      end
      if (e == 11) begin
        // R8: cleared after the 10th edge; R7: not yet set
        chk(!alarm_hi && !alarm_lo, "R8 clear", {alarm_hi, alarm_lo}, 0);
      end
      if (e == 12) begin
        // R5 R6 R7
        chk(alarm_hi == eh && alarm_lo == el, "R7 flags", {alarm_hi, alarm_lo}, {eh, el});
        // R9
        chk({alarm_sel, alarm_pin} == route_exp(rt, eh, el), "R9 route",
            {alarm_sel, alarm_pin}, route_exp(rt, eh, el));
      end
    end
    prev_hi = eh; prev_lo = el;
    @(negedge clk) cmd_valid = 1; cmd_word = cmd;
    @(negedge clk) cmd_valid = 0; cmd_word = 0;
  endtask

  task automatic pframe(input logic [15:0] cmd);
    frame(cmd, 3'b110, 1'b0, 4'd0, 12'h400, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!alarm_hi && !alarm_lo && !prog_active, "R1 reset", {alarm_hi, alarm_lo, prog_active}, 0);

    pframe(16'h8000);
    chk(!prog_active, "R2 no open", prog_active, 0);
    pframe(16'hC000);
    chk(prog_active && prog_group == 2'd0, "R2 open g0", {prog_active, prog_group}, 3'b100);
    pframe(16'h6200);   // R3 ch1 upper 0x200
    pframe(16'h4100);   // R3 ch1 lower 0x100
    chk(prog_active, "R4 stays open", prog_active, 1);
    pframe(16'hB3F0);   // ch2 upper 0x3F0, exit
    chk(!prog_active, "R4 exit", prog_active, 0);
    pframe(16'hF000);
    chk(prog_active && prog_group == 2'd3, "R2 open g3", {prog_active, prog_group}, 3'b111);
    pframe(16'hD080);   // ch15 lower 0x080, exit
    pframe(16'hE000);
    pframe(16'h2050);   // ch8 upper 0x050
    pframe(16'h1040);   // R4 taken as data: ch8 lower 0x040, exit
    chk(!prog_active, "R4 data word exit", prog_active, 0);

    for (int i = 0; i < NV; i++)
      frame(16'h0000, VEC[i][21:19], VEC[i][18], VEC[i][17:14], VEC[i][13:2],
            VEC[i][1], VEC[i][0]);
    pframe(16'h0000);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule